// File: doc/BRIEF.md
# Encoded Program Counter Update Unit

This block owns the 16-bit program counter of a small byte-oriented processor core. Rather than decoding every jump, call and return instruction itself, it reacts to a compact 3-bit change code that the arithmetic unit produces while it evaluates branch conditions. The code picks one of a handful of update paths. These are: step past the bytes just fetched, load an absolute target built from the two instruction parameter bytes, add a signed 8-bit displacement taken from either parameter byte, restore an address popped from the stack, or jump to a call or interrupt entry address supplied by the instruction-analysis logic.

An instruction cycle is divided into four phases. The counter moves only on the final phase of the final cycle of an instruction, and it holds its value at every other time. Alongside the counter the block presents the address of the next sequential instruction. This is the value that a call or an interrupt pushes onto the stack. The stack memory and the condition logic are outside the block; the popped value arrives on an input.

Top module: `pc_steer_unit`

## Requirements
- R1: A clock edge with `rst_n` low sets `pc` to 0000H.
- R2: `pc` changes only at a clock edge where `phase` equals 3 and `last_cycle` is 1; at every other edge it keeps its value whatever the change code and data inputs are.
- R3: Change code 0 sets `pc` to `pc + fetch_len` (fetch_len is 1 to 3), wrapping modulo 2^16.
- R4: Change code 1 loads `pc` with `{parm_hi, parm_lo}`, so `parm_hi` is the upper byte.
- R5: Change code 2 sets `pc` to `pc + fetch_len` plus `parm_hi` read as a signed two's-complement byte, wrapping modulo 2^16.
- R6: Change code 3 sets `pc` to `pc + fetch_len` plus `parm_lo` read as a signed two's-complement byte, wrapping modulo 2^16.
- R7: Change code 4 loads `pc` with `stack_pc`. For example, a return from interrupt taken at 003FH with 0025H on the stack leaves `pc` at 0025H.
- R8: Change code 5 loads `pc` with `entry_addr`.
- R9: Change codes 6 and 7 act as code 0 (a plain step by `fetch_len`).
- R10: `push_val` equals `pc + fetch_len` (modulo 2^16) combinationally, in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 2 | Phase within the current instruction cycle, 0 to 3 |
| last_cycle | input | 1 | High during the final cycle of the current instruction |
| chg_code | input | 3 | Update-path selector from the arithmetic unit |
| fetch_len | input | 2 | Number of bytes in the current instruction (1 to 3) |
| parm_hi | input | 8 | First instruction parameter byte |
| parm_lo | input | 8 | Second instruction parameter byte |
| stack_pc | input | 16 | Address popped from the stack |
| entry_addr | input | 16 | Call or interrupt entry address |
| pc | output | 16 | Current program counter |
| push_val | output | 16 | Address of the next sequential instruction, to be pushed |

## Verification
`push_val` is combinational, so the bench checks it in the same half-cycle in which it drives `fetch_len`, before any clock edge. A counter update is due on the single rising edge at which `phase` is 3 and `last_cycle` is high. The bench drives inputs on the falling edge and compares `pc` on the next falling edge, one register stage later. Hold cases drive every other phase and the not-last-cycle case with a load code and differing data, then read `pc` after that edge. Reset is checked on the falling edge that follows the first rising edge with `rst_n` low.

// File: rtl/pcs_pkg.sv
// Shared constants for the program counter update unit.
// Assumes the change code is 3 bits wide; codes 6 and 7 are unassigned.
package pcs_pkg;
    localparam int unsigned CODE_W = 3;

    localparam logic [CODE_W-1:0] CHG_STEP   = 3'd0;
    localparam logic [CODE_W-1:0] CHG_ABS    = 3'd1;
    localparam logic [CODE_W-1:0] CHG_REL_HI = 3'd2;
    localparam logic [CODE_W-1:0] CHG_REL_LO = 3'd3;
    localparam logic [CODE_W-1:0] CHG_STACK  = 3'd4;
    localparam logic [CODE_W-1:0] CHG_ENTRY  = 3'd5;
endpackage

// File: rtl/pcs_update_gate.sv
// Update gate: decides on which clock edge the program counter may move.
// Assumes phases count 0..PHASES-1 and that the last phase is PHASES-1.
module pcs_update_gate #(
    parameter int unsigned PHASES = 4,
    localparam int unsigned PH_W  = $clog2(PHASES)
) (
    input  logic [PH_W-1:0] phase_i,
    input  logic            last_cycle_i,
    output logic            upd_o
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    // Enable only on the final phase of the final instruction cycle.
    always_comb begin
        upd_o = last_cycle_i && (phase_i == LAST_PH);
    end
endmodule

// File: rtl/pcs_next_calc.sv
// Next-address calculator: forms the sequential address and selects the
// candidate next counter value from the change code.
// Assumes PC_W == 2*PARM_W (the absolute target is the two parameter bytes)
// and PC_W > PARM_W and PC_W > LEN_W.
module pcs_next_calc
    import pcs_pkg::*;
#(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned PARM_W = 8,
    parameter int unsigned LEN_W  = 2
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [PARM_W-1:0] parm_hi_i,
    input  logic [PARM_W-1:0] parm_lo_i,
    input  logic [PC_W-1:0]   stack_i,
    input  logic [PC_W-1:0]   entry_i,
    output logic [PC_W-1:0]   seq_o,
    output logic [PC_W-1:0]   nxt_o
);
    localparam int unsigned N_REL = 2;
    localparam int unsigned EXT_W = PC_W - PARM_W;

    logic [PARM_W-1:0] rel_src [N_REL];
    logic [PC_W-1:0]   rel_off [N_REL];
    logic [PC_W-1:0]   rel_tgt [N_REL];
    logic [PC_W-1:0]   abs_tgt;

    assign rel_src[0] = parm_hi_i;
    assign rel_src[1] = parm_lo_i;

    // Sequential address: counter stepped past the fetched bytes.
    always_comb begin
        seq_o = pc_i + {{(PC_W-LEN_W){1'b0}}, len_i};
    end

    // One sign-extending displacement adder per parameter byte.
    for (genvar g = 0; g < N_REL; g++) begin : g_rel
        always_comb begin
            rel_off[g] = {{EXT_W{rel_src[g][PARM_W-1]}}, rel_src[g]};
            rel_tgt[g] = seq_o + rel_off[g];
        end
    end

    // Absolute target: first parameter byte is the upper half.
    always_comb begin
        abs_tgt = PC_W'({parm_hi_i, parm_lo_i});
    end

    // Select the candidate next value; unassigned codes fall back to a step.
    always_comb begin
        unique case (code_i)
            CHG_ABS:    nxt_o = abs_tgt;
            CHG_REL_HI: nxt_o = rel_tgt[0];
            CHG_REL_LO: nxt_o = rel_tgt[1];
            CHG_STACK:  nxt_o = stack_i;
            CHG_ENTRY:  nxt_o = entry_i;
            default:    nxt_o = seq_o;
        endcase
    end
endmodule

// File: rtl/pcs_reg.sv
// Program counter register with synchronous active-low reset and a load
// enable. Assumes the reset value is zero.
module pcs_reg #(
    parameter int unsigned PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [PC_W-1:0] d_i,
    output logic [PC_W-1:0] q_o
);
    // Hold the counter; clear on reset, load when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (en_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/pc_steer_unit.sv
// Encoded program counter update unit (top).
// Moves the program counter once per instruction, on the last phase of the
// last cycle, along the path chosen by the change code. Also presents the
// sequential address for pushing on calls and interrupts.
// Assumes the change code and data inputs are stable during the update phase.
module pc_steer_unit
    import pcs_pkg::*;
#(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned PARM_W = 8,
    parameter int unsigned LEN_W  = 2,
    parameter int unsigned PHASES = 4,
    localparam int unsigned PH_W  = $clog2(PHASES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase,
    input  logic              last_cycle,
    input  logic [CODE_W-1:0] chg_code,
    input  logic [LEN_W-1:0]  fetch_len,
    input  logic [PARM_W-1:0] parm_hi,
    input  logic [PARM_W-1:0] parm_lo,
    input  logic [PC_W-1:0]   stack_pc,
    input  logic [PC_W-1:0]   entry_addr,
    output logic [PC_W-1:0]   pc,
    output logic [PC_W-1:0]   push_val
);
    logic            upd;
    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] nxt_addr;

    pcs_update_gate #(.PHASES(PHASES)) u_gate (
        .phase_i      (phase),
        .last_cycle_i (last_cycle),
        .upd_o        (upd)
    );

    pcs_next_calc #(.PC_W(PC_W), .PARM_W(PARM_W), .LEN_W(LEN_W)) u_calc (
        .pc_i      (pc),
        .code_i    (chg_code),
        .len_i     (fetch_len),
        .parm_hi_i (parm_hi),
        .parm_lo_i (parm_lo),
        .stack_i   (stack_pc),
        .entry_i   (entry_addr),
        .seq_o     (seq_addr),
        .nxt_o     (nxt_addr)
    );

    pcs_reg #(.PC_W(PC_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (upd),
        .d_i   (nxt_addr),
        .q_o   (pc)
    );

    // The pushed return address is the next sequential instruction.
    always_comb begin
        push_val = seq_addr;
    end
endmodule

// File: rtl/pc_steer_unit_chk.sv
// Checker for pc_steer_unit: relates the counter at each edge to the inputs
// sampled at the previous edge. Attached by the bind statement below.
module pc_steer_unit_chk #(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned PARM_W = 8,
    parameter int unsigned LEN_W  = 2,
    parameter int unsigned PHASES = 4,
    localparam int unsigned PH_W  = $clog2(PHASES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PH_W-1:0]   phase,
    input logic              last_cycle,
    input logic [2:0]        chg_code,
    input logic [LEN_W-1:0]  fetch_len,
    input logic [PARM_W-1:0] parm_hi,
    input logic [PARM_W-1:0] parm_lo,
    input logic [PC_W-1:0]   stack_pc,
    input logic [PC_W-1:0]   entry_addr,
    input logic [PC_W-1:0]   pc,
    input logic [PC_W-1:0]   push_val
);
    logic            go;
    logic [PC_W-1:0] len_x;
    logic [PC_W-1:0] off_hi;
    logic [PC_W-1:0] off_lo;
    logic [PC_W-1:0] abs_x;

    // Independent views of the inputs at full counter width.
    always_comb begin
        go     = last_cycle && (int'(phase) == int'(PHASES) - 1);
        len_x  = PC_W'(fetch_len);
        off_hi = PC_W'($signed(parm_hi));
        off_lo = PC_W'($signed(parm_lo));
        abs_x  = PC_W'({parm_hi, parm_lo});
    end

    // R1: reset clears the counter.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> pc == '0);

    // R2: no movement outside the update phase.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(pc));

    // R3, R9: step codes.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        go && (chg_code == 3'd0 || chg_code > 3'd5) |=> pc == $past(pc) + $past(len_x));

    // R4: absolute load.
    a_r4_abs: assert property (@(posedge clk) disable iff (!rst_n)
        go && chg_code == 3'd1 |=> pc == $past(abs_x));

    // R5: displacement from the first parameter byte.
    a_r5_rel_hi: assert property (@(posedge clk) disable iff (!rst_n)
        go && chg_code == 3'd2 |=> pc == $past(pc) + $past(len_x) + $past(off_hi));

    // R6: displacement from the second parameter byte.
    a_r6_rel_lo: assert property (@(posedge clk) disable iff (!rst_n)
        go && chg_code == 3'd3 |=> pc == $past(pc) + $past(len_x) + $past(off_lo));

    // R7: restore from stack.
    a_r7_stack: assert property (@(posedge clk) disable iff (!rst_n)
        go && chg_code == 3'd4 |=> pc == $past(stack_pc));

    // R8: entry address load.
    a_r8_entry: assert property (@(posedge clk) disable iff (!rst_n)
        go && chg_code == 3'd5 |=> pc == $past(entry_addr));

    // R10: pushed value tracks the sequential address.
    a_r10_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_val == pc + len_x);
endmodule

bind pc_steer_unit pc_steer_unit_chk #(
    .PC_W(PC_W), .PARM_W(PARM_W), .LEN_W(LEN_W), .PHASES(PHASES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .last_cycle (last_cycle),
    .chg_code   (chg_code),
    .fetch_len  (fetch_len),
    .parm_hi    (parm_hi),
    .parm_lo    (parm_lo),
    .stack_pc   (stack_pc),
    .entry_addr (entry_addr),
    .pc         (pc),
    .push_val   (push_val)
);

// File: tb/pc_steer_unit_test.sv
// Bench for pc_steer_unit: a vector table walked by one loop, then directed
// tests for reset, hold, wrap, negative displacement and the return example.
module pc_steer_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  phase;
    logic        last_cycle;
    logic [2:0]  chg_code;
    logic [1:0]  fetch_len;
    logic [7:0]  parm_hi;
    logic [7:0]  parm_lo;
    logic [15:0] stack_pc;
    logic [15:0] entry_addr;
    logic [15:0] pc;
    logic [15:0] push_val;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pc_steer_unit uut (
        .clk(clk), .rst_n(rst_n), .phase(phase), .last_cycle(last_cycle),
        .chg_code(chg_code), .fetch_len(fetch_len), .parm_hi(parm_hi),
        .parm_lo(parm_lo), .stack_pc(stack_pc), .entry_addr(entry_addr),
        .pc(pc), .push_val(push_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector fields: code[52:50] len[49:48] hi[47:40] lo[39:32] stk[31:16] ent[15:0]
    localparam logic [52:0] VEC [N_VEC] = '{
        {3'd0, 2'd1, 8'h00, 8'h00, 16'h0000, 16'h0000},
        {3'd0, 2'd3, 8'h11, 8'h22, 16'h0000, 16'h0000},
        {3'd1, 2'd3, 8'h12, 8'h34, 16'hAAAA, 16'hBBBB},
        {3'd2, 2'd2, 8'h10, 8'hF0, 16'hAAAA, 16'hBBBB},
        {3'd3, 2'd2, 8'h05, 8'hF0, 16'hAAAA, 16'hBBBB},
        {3'd5, 2'd3, 8'h00, 8'h00, 16'hAAAA, 16'h0003},
        {3'd5, 2'd2, 8'h55, 8'h66, 16'h1111, 16'h0013},
        {3'd4, 2'd1, 8'h77, 8'h88, 16'h1238, 16'h9999},
        {3'd6, 2'd2, 8'h01, 8'h02, 16'h4444, 16'h5555},
        {3'd7, 2'd3, 8'h01, 8'h02, 16'h4444, 16'h5555}
    };

    // Expected next counter, written from the requirements.
    function automatic logic [15:0] model(input logic [15:0] p, input logic [2:0] c,
                                          input logic [1:0] l, input logic [7:0] h,
                                          input logic [7:0] lo, input logic [15:0] s,
                                          input logic [15:0] e);
        logic [15:0] nx;
        nx = p + {14'd0, l};
        case (c)
            3'd1:    return {h, lo};
            3'd2:    return nx + {{8{h[7]}}, h};
            3'd3:    return nx + {{8{lo[7]}}, lo};
            3'd4:    return s;
            3'd5:    return e;
            default: return nx;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0:    return "R3";
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd3:    return "R6";
            3'd4:    return "R7";
            3'd5:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; the counter is read one edge later.
    task automatic drive(input logic [1:0] ph, input logic lc, input logic [2:0] c,
                         input logic [1:0] l, input logic [7:0] h, input logic [7:0] lo,
                         input logic [15:0] s, input logic [15:0] e);
        @(negedge clk);
        phase = ph; last_cycle = lc; chg_code = c; fetch_len = l;
        parm_hi = h; parm_lo = lo; stack_pc = s; entry_addr = e;
    endtask

    task automatic idle();
        drive(2'd0, 1'b0, 3'd0, 2'd1, 8'h00, 8'h00, 16'h0000, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_pc;
        rst_n = 1'b0;
        idle();
        @(negedge clk);
        @(negedge clk);
        check("R1", "reset value", pc, 16'h0000);
        rst_n = 1'b1;
        exp_pc = 16'h0000;

        // Table walk: one update per entry, push value checked before the edge.
        for (int i = 0; i < N_VEC; i++) begin
            logic [52:0] v;
            v = VEC[i];
            drive(2'd3, 1'b1, v[52:50], v[49:48], v[47:40], v[39:32], v[31:16], v[15:0]);
            #1;
            check("R10", "push value", push_val, exp_pc + {14'd0, v[49:48]});
            exp_pc = model(exp_pc, v[52:50], v[49:48], v[47:40], v[39:32], v[31:16], v[15:0]);
            idle();
            check(tag_of(v[52:50]), "table update", pc, exp_pc);
        end

        // R2: phases 0..2 of the last cycle do not move the counter.
        for (int p = 0; p < 3; p++) begin
            drive(2'(p), 1'b1, 3'd1, 2'd1, 8'hDE, 8'hAD, 16'h0101, 16'h0202);
            @(negedge clk);
            check("R2", "hold in early phase", pc, exp_pc);
        end
        // R2: last phase but not the last cycle.
        drive(2'd3, 1'b0, 3'd5, 2'd3, 8'hDE, 8'hAD, 16'h0101, 16'h0202);
        @(negedge clk);
        check("R2", "hold when not last cycle", pc, exp_pc);

        // R3: wrap past FFFFH.
        drive(2'd3, 1'b1, 3'd1, 2'd1, 8'hFF, 8'hFE, 16'h0, 16'h0);
        idle();
        check("R4", "load FFFE", pc, 16'hFFFE);
        drive(2'd3, 1'b1, 3'd0, 2'd3, 8'h00, 8'h00, 16'h0, 16'h0);
        #1;
        check("R10", "push value wraps", push_val, 16'h0001);
        idle();
        check("R3", "step wraps to 0001", pc, 16'h0001);

        // R5: most negative displacement from 0100H, length 2.
        drive(2'd3, 1'b1, 3'd1, 2'd1, 8'h01, 8'h00, 16'h0, 16'h0);
        drive(2'd3, 1'b1, 3'd2, 2'd2, 8'h80, 8'h7F, 16'h0, 16'h0);
        idle();
        check("R5", "displacement -128", pc, 16'h0082);
        // R6: largest positive displacement from 0082H, length 3.
        drive(2'd3, 1'b1, 3'd3, 2'd3, 8'h80, 8'h7F, 16'h0, 16'h0);
        idle();
        check("R6", "displacement +127", pc, 16'h0104);

        // R7: return from interrupt at 003FH back to 0025H.
        drive(2'd3, 1'b1, 3'd1, 2'd1, 8'h00, 8'h3F, 16'h0, 16'h0);
        drive(2'd3, 1'b1, 3'd4, 2'd1, 8'h00, 8'h00, 16'h0025, 16'h0);
        idle();
        check("R7", "return restores 0025", pc, 16'h0025);

        // R1: reset in mid-run with an update request present.
        drive(2'd3, 1'b1, 3'd5, 2'd1, 8'h00, 8'h00, 16'h0, 16'h7777);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "reset overrides update", pc, 16'h0000);
        rst_n = 1'b1;
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule